// File: doc/BRIEF.md
# Temperature Alarm Status Unit

This unit takes a stream of signed temperature samples and keeps two status flags up to date. One flag is for over-temperature (OT) and one is for under-temperature (UT). Each flag is judged against a trip threshold and a release threshold. The high side trips on `th_i` and releases on `th_hyst_i`. The low side trips on `tl_i` and releases on `tl_hyst_i`. Samples are 16-bit two's complement values in steps of 1/16 °C. The block sits behind a temperature converter, and all of its threshold and configuration inputs are held by the surrounding register logic.

Two behaviours are available. In comparator mode each flag follows the temperature, with hysteresis applied. In interrupt mode a flag is set on an event and is cleared by a status read. After each set, the unit arms itself for the opposite crossing. A trip only counts after a programmable number of consecutive faulting samples (1, 2, 4 or 8). The combined alarm is presented as a logic level at a selectable polarity, together with a pull-low enable for an open-drain pad.

Top module: `temp_alarm_unit`

## Requirements
- R1: In comparator mode (`cfg_i[9]`=0), OT becomes 1 one clock after the qualifying valid sample with `sample_i > th_i`. OT holds while the sample stays between `th_hyst_i` and `th_i`.
- R2: In comparator mode, OT becomes 0 one clock after a valid sample with `sample_i < th_hyst_i`, provided that sample does not trip.
- R3: In comparator mode, UT mirrors R1 and R2. It sets on `sample_i < tl_i` and clears on `sample_i > tl_hyst_i`.
- R4: `cfg_i[11:10]` = k requires 2^k consecutive faulting valid samples before a trip takes effect. 00 needs 1, 01 needs 2, 10 needs 4 and 11 needs 8.
- R5: Any valid sample that does not meet a side's trip condition restarts that side's consecutive-fault count from zero.
- R6: In interrupt mode (`cfg_i[9]`=1), a qualified trip sets the flag. The flag stays at 1 until a cycle with `stat_rd_i`=1, which clears it on the next clock.
- R7: In interrupt mode, each time a flag is set the unit arms the opposite event. After a trip it waits for a release crossing (OT: `sample_i < th_hyst_i`; UT: `sample_i > tl_hyst_i`), and after a release crossing it waits for a trip again. An event that finds its flag still set has no effect.
- R8: A flag changes only on a valid sample, on a read in interrupt mode, or on shutdown. A read in comparator mode has no effect.
- R9: In interrupt mode, if a status read and an armed event fall in the same cycle, the flag ends at 1.
- R10: `shutdown_i`=1 clears OT, UT, the fault counts and the arming on the next clock. Samples presented while it is high are ignored.
- R11: `cfg_i[8]` sets the alarm polarity. When OT or UT is 1, `alarm_lvl_o` equals `cfg_i[8]`; otherwise it equals its inverse. `alarm_drv_low_o` is always the inverse of `alarm_lvl_o`.
- R12: After reset, OT and UT are 0 and the alarm is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_vld_i | input | 1 | New temperature sample strobe |
| sample_i | input | 16 | Signed temperature, 1/16 °C per LSB |
| th_i | input | 16 | Over-temperature trip threshold |
| th_hyst_i | input | 16 | Over-temperature release threshold |
| tl_i | input | 16 | Under-temperature trip threshold |
| tl_hyst_i | input | 16 | Under-temperature release threshold |
| cfg_i | input | 4 | Bits 11:8: [11:10] fault count code, [9] interrupt mode, [8] polarity |
| stat_rd_i | input | 1 | Status register read strobe |
| shutdown_i | input | 1 | Shutdown request, clears status |
| ot_o | output | 1 | Over-temperature status |
| ut_o | output | 1 | Under-temperature status |
| alarm_lvl_o | output | 1 | Alarm logic level at selected polarity |
| alarm_drv_low_o | output | 1 | Pull-low enable for an open-drain pad |

## Verification
In interrupt mode, a status read and a new armed event can fall in the same cycle. The bench provokes this by reading OT clear while the OT side is armed for a release crossing. It then presents, in one cycle, both the read strobe and a sample below the release threshold, and expects OT to be 1 afterwards with the arming flipped. The following read and trip steps confirm that the arming did flip.

// File: rtl/temp_alarm_pkg.sv
package temp_alarm_pkg;
  localparam int TEMP_W   = 16;
  localparam int FQ_W     = 2;
  localparam int POL_BIT  = 8;
  localparam int MODE_BIT = 9;
  localparam int FQ_LO    = 10;
  localparam int CFG_HI   = FQ_LO + FQ_W - 1;

  typedef logic signed [TEMP_W-1:0] temp_t;
  typedef enum logic {ARM_TRIP = 1'b0, ARM_RELEASE = 1'b1} arm_e;
endpackage

// File: rtl/alarm_fault_queue.sv
module alarm_fault_queue #(
  parameter int FQ_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            step_i,
  input  logic            fault_i,
  input  logic [FQ_W-1:0] fq_sel_i,
  output logic            qual_o
);
  localparam int MAX_CNT = 1 << ((1 << FQ_W) - 1);
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] need_m1;

  assign need_m1 = CNT_W'((1 << fq_sel_i) - 1);
  assign qual_o  = step_i && fault_i && (cnt_q >= need_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clr_i)     cnt_q <= '0;
    else if (step_i) begin
      if (!fault_i)                       cnt_q <= '0;
      else if (cnt_q != CNT_W'(MAX_CNT))  cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/alarm_status_channel.sv
module alarm_status_channel
  import temp_alarm_pkg::*;
#(
  parameter bit HIGH_SIDE = 1'b1,
  parameter int QW        = FQ_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sample_vld_i,
  input  temp_t         sample_i,
  input  temp_t         trip_thr_i,
  input  temp_t         rel_thr_i,
  input  logic [QW-1:0] fq_sel_i,
  input  logic          int_mode_i,
  input  logic          rd_i,
  input  logic          shutdown_i,
  output logic          stat_o
);
  logic fault, relax, qual, step, event_hit;
  arm_e arm_q;

  generate
    if (HIGH_SIDE) begin : g_high
      assign fault = sample_i > trip_thr_i;
      assign relax = sample_i < rel_thr_i;
    end else begin : g_low
      assign fault = sample_i < trip_thr_i;
      assign relax = sample_i > rel_thr_i;
    end
  endgenerate

  assign step = sample_vld_i && !shutdown_i;

  alarm_fault_queue #(.FQ_W(QW)) u_fq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (shutdown_i),
    .step_i   (step),
    .fault_i  (fault),
    .fq_sel_i (fq_sel_i),
    .qual_o   (qual)
  );

  // armed event for interrupt mode
  assign event_hit = (arm_q == ARM_TRIP) ? qual : (step && relax);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o <= 1'b0;
      arm_q  <= ARM_TRIP;
    end else if (shutdown_i) begin
      stat_o <= 1'b0;
      arm_q  <= ARM_TRIP;
    end else if (!int_mode_i) begin
      arm_q <= ARM_TRIP;
      if (qual)                stat_o <= 1'b1;
      else if (step && relax)  stat_o <= 1'b0;
    end else begin
      // a new event outranks a read in the same cycle
      if (event_hit && (!stat_o || rd_i)) begin
        stat_o <= 1'b1;
        arm_q  <= (arm_q == ARM_TRIP) ? ARM_RELEASE : ARM_TRIP;
      end else if (rd_i) begin
        stat_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/alarm_pin_drive.sv
module alarm_pin_drive (
  input  logic ot_i,
  input  logic ut_i,
  input  logic pol_i,
  output logic lvl_o,
  output logic drv_low_o
);
  logic active;
  assign active    = ot_i || ut_i;
  assign lvl_o     = pol_i ? active : !active;
  assign drv_low_o = !lvl_o;
endmodule

// File: rtl/temp_alarm_unit.sv
module temp_alarm_unit
  import temp_alarm_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sample_vld_i,
  input  logic signed [TEMP_W-1:0] sample_i,
  input  logic signed [TEMP_W-1:0] th_i,
  input  logic signed [TEMP_W-1:0] th_hyst_i,
  input  logic signed [TEMP_W-1:0] tl_i,
  input  logic signed [TEMP_W-1:0] tl_hyst_i,
  input  logic [CFG_HI:POL_BIT]    cfg_i,
  input  logic                     stat_rd_i,
  input  logic                     shutdown_i,
  output logic                     ot_o,
  output logic                     ut_o,
  output logic                     alarm_lvl_o,
  output logic                     alarm_drv_low_o
);
  localparam int N_SIDE = 2;

  temp_t trip_thr [N_SIDE];
  temp_t rel_thr  [N_SIDE];
  logic  stat     [N_SIDE];

  assign trip_thr[0] = th_i;
  assign rel_thr[0]  = th_hyst_i;
  assign trip_thr[1] = tl_i;
  assign rel_thr[1]  = tl_hyst_i;

  for (genvar d = 0; d < N_SIDE; d++) begin : g_side
    alarm_status_channel #(.HIGH_SIDE(d == 0), .QW(FQ_W)) u_ch (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .sample_vld_i (sample_vld_i),
      .sample_i     (sample_i),
      .trip_thr_i   (trip_thr[d]),
      .rel_thr_i    (rel_thr[d]),
      .fq_sel_i     (cfg_i[CFG_HI:FQ_LO]),
      .int_mode_i   (cfg_i[MODE_BIT]),
      .rd_i         (stat_rd_i),
      .shutdown_i   (shutdown_i),
      .stat_o       (stat[d])
    );
  end

  assign ot_o = stat[0];
  assign ut_o = stat[1];

  alarm_pin_drive u_pin (
    .ot_i      (stat[0]),
    .ut_i      (stat[1]),
    .pol_i     (cfg_i[POL_BIT]),
    .lvl_o     (alarm_lvl_o),
    .drv_low_o (alarm_drv_low_o)
  );
endmodule

// File: rtl/temp_alarm_chk.sv
module temp_alarm_chk (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sample_vld_i,
  input logic signed [15:0] sample_i,
  input logic signed [15:0] th_i,
  input logic signed [15:0] th_hyst_i,
  input logic signed [15:0] tl_i,
  input logic signed [15:0] tl_hyst_i,
  input logic [11:8]        cfg_i,
  input logic               stat_rd_i,
  input logic               shutdown_i,
  input logic               ot_o,
  input logic               ut_o,
  input logic               alarm_lvl_o,
  input logic               alarm_drv_low_o
);
  // R1
  cmp_ot_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i[9] && sample_vld_i && !shutdown_i && cfg_i[11:10] == 2'd0 && sample_i > th_i |=> ot_o);

  // R2
  cmp_ot_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i[9] && sample_vld_i && !shutdown_i && sample_i < th_hyst_i && !(sample_i > th_i) |=> !ot_o);

  // R3
  cmp_ut_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i[9] && sample_vld_i && !shutdown_i && cfg_i[11:10] == 2'd0 && sample_i < tl_i |=> ut_o);

  // R3
  cmp_ut_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i[9] && sample_vld_i && !shutdown_i && sample_i > tl_hyst_i && !(sample_i < tl_i) |=> !ut_o);

  // R6
  irq_read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i[9] && stat_rd_i && !sample_vld_i && !shutdown_i |=> !ot_o && !ut_o);

  // R8
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_vld_i && !shutdown_i && !(cfg_i[9] && stat_rd_i) |=> $stable(ot_o) && $stable(ut_o));

  // R10
  shutdown_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_i |=> !ot_o && !ut_o);

  // R11
  pin_polarity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_drv_low_o != alarm_lvl_o) &&
    ((ot_o || ut_o) == (alarm_lvl_o == cfg_i[8])));
endmodule

bind temp_alarm_unit temp_alarm_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .sample_vld_i    (sample_vld_i),
  .sample_i        (sample_i),
  .th_i            (th_i),
  .th_hyst_i       (th_hyst_i),
  .tl_i            (tl_i),
  .tl_hyst_i       (tl_hyst_i),
  .cfg_i           (cfg_i),
  .stat_rd_i       (stat_rd_i),
  .shutdown_i      (shutdown_i),
  .ot_o            (ot_o),
  .ut_o            (ut_o),
  .alarm_lvl_o     (alarm_lvl_o),
  .alarm_drv_low_o (alarm_drv_low_o)
);

// File: tb/sim_temp_alarm_unit.sv
`timescale 1ns/1ps
module sim_temp_alarm_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic signed [15:0] smp = '0;
  logic signed [15:0] th = 16'sd1600, th_hy = 16'sd1440, tl = -16'sd640, tl_hy = -16'sd480;
  logic [1:0] fq = 2'd0;
  logic intm = 1'b0, pol = 1'b0;
  logic rd = 1'b0, sd = 1'b0;
  logic ot, ut, lvl, drv_low;
  int checks = 0, errors = 0;

  typedef struct { logic ot; logic ut; logic lvl; string req; } exp_t;
  exp_t exp_q[$];
  exp_t cur;

  always #2 clk = !clk;

  temp_alarm_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .sample_vld_i(vld), .sample_i(smp),
    .th_i(th), .th_hyst_i(th_hy), .tl_i(tl), .tl_hyst_i(tl_hy),
    .cfg_i({fq, intm, pol}), .stat_rd_i(rd), .shutdown_i(sd),
    .ot_o(ot), .ut_o(ut), .alarm_lvl_o(lvl), .alarm_drv_low_o(drv_low)
  );

  task automatic cmp(input logic act, input logic expv, input string what, input string req);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, what, act, expv, $time);
    end
  endtask

  // monitor: compares on the falling edge after each driven step
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      cur = exp_q.pop_front();
      cmp(ot, cur.ot, "ot", cur.req);
      cmp(ut, cur.ut, "ut", cur.req);
      cmp(lvl, cur.lvl, "alarm_lvl", cur.req);
      cmp(drv_low, !cur.lvl, "drv_low", cur.req);
    end
  end

  // driver: apply inputs, let one edge pass, queue the expected result
  task automatic step(input logic v, input int t, input logic r, input logic s,
                      input logic eo, input logic eu, input string req);
    exp_t e;
    vld = v; smp = 16'(t); rd = r; sd = s;
    @(posedge clk);
    #1;
    e.ot = eo; e.ut = eu; e.req = req;
    e.lvl = (eo || eu) ? pol : !pol;
    exp_q.push_back(e);
    @(negedge clk);
    #1;
    vld = 1'b0; rd = 1'b0; sd = 1'b0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, "R12");
    // comparator, queue of 1, active low
    step(1, 1700, 0, 0, 1, 0, "R1");
    step(1, 1500, 0, 0, 1, 0, "R1");
    step(1, 1400, 0, 0, 0, 0, "R2");
    step(1, 1700, 0, 0, 1, 0, "R1");
    step(0, 0, 1, 0, 1, 0, "R8");
    step(1, 1000, 0, 0, 0, 0, "R2");
    step(1, -700, 0, 0, 0, 1, "R3");
    step(1, -500, 0, 0, 0, 1, "R3");
    step(1, -400, 0, 0, 0, 0, "R3");
    // fault queue of 4
    fq = 2'd2;
    for (int i = 0; i < 3; i++) step(1, 1700, 0, 0, 0, 0, "R4");
    step(1, 1700, 0, 0, 1, 0, "R4");
    step(1, 1000, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 3; i++) step(1, 1700, 0, 0, 0, 0, "R5");
    step(1, 1500, 0, 0, 0, 0, "R5");
    for (int i = 0; i < 3; i++) step(1, 1700, 0, 0, 0, 0, "R5");
    step(1, 1700, 0, 0, 1, 0, "R5");
    step(1, 1000, 0, 0, 0, 0, "R2");
    fq = 2'd1;
    step(1, 1700, 0, 0, 0, 0, "R4");
    step(1, 1700, 0, 0, 1, 0, "R4");
    step(1, 1000, 0, 0, 0, 0, "R2");
    fq = 2'd3;
    for (int i = 0; i < 7; i++) step(1, 1700, 0, 0, 0, 0, "R4");
    step(1, 1700, 0, 0, 1, 0, "R4");
    step(1, 1000, 0, 0, 0, 0, "R2");
    fq = 2'd0;
    // interrupt mode
    intm = 1'b1;
    step(1, 1700, 0, 0, 1, 0, "R6");
    step(1, 1000, 0, 0, 1, 0, "R6");
    step(0, 0, 1, 0, 0, 0, "R6");
    step(1, 1700, 0, 0, 0, 0, "R7");
    step(1, 1000, 0, 0, 1, 0, "R7");
    step(1, 1000, 0, 0, 1, 0, "R7");
    step(0, 0, 1, 0, 0, 0, "R6");
    step(1, 1000, 0, 0, 0, 0, "R7");
    step(1, 1700, 0, 0, 1, 0, "R7");
    step(0, 0, 1, 0, 0, 0, "R6");
    // read and armed release event in one cycle
    step(1, 1000, 1, 0, 1, 0, "R9");
    step(0, 0, 1, 0, 0, 0, "R9");
    step(1, 1000, 0, 0, 0, 0, "R9");
    step(1, -700, 0, 0, 0, 1, "R6");
    step(0, 0, 1, 0, 0, 0, "R6");
    step(1, -400, 0, 0, 0, 1, "R7");
    step(0, 0, 1, 0, 0, 0, "R6");
    // shutdown
    step(1, 1700, 0, 0, 1, 0, "R6");
    step(0, 0, 0, 1, 0, 0, "R10");
    step(1, 1700, 0, 1, 0, 0, "R10");
    step(1, 1700, 0, 0, 1, 0, "R10");
    // active-high polarity in comparator mode
    intm = 1'b0; pol = 1'b1;
    step(1, 1700, 0, 0, 1, 0, "R11");
    step(1, 1000, 0, 0, 0, 0, "R11");
    step(1, -700, 0, 0, 0, 1, "R11");
    step(1, -400, 0, 0, 0, 0, "R11");
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule